// File: doc/BRIEF.md
# Event Counter Group with StreamID Filtering

This block is a memory-mapped group of event counters for an address-translation unit. Each counter selects one of several event inputs through its own event-type register and counts a pulse only when the StreamID that comes with the event passes a filter. The filter compares either the exact value, or only the upper bits of a pattern whose low-order run of ones, together with the zero just above it, marks the bits to ignore. Software starts and stops counters with paired set and clear addresses. Overflow flags and per-counter interrupt enables use the same kind of pairing. A single level interrupt output is gated by a global interrupt-enable bit.

Software reaches all state through a flat 32-bit register port. Writes take effect on a clock edge and reads are combinational. Counters may be preloaded, for example a few counts below wrap so that an interrupt comes after a chosen number of events. A build-time option makes counter 0's filter the only filter for the whole group. A read-only configuration word reports the counter count, the counter width and that option. When counters are wider than 32 bits they occupy two words each.

Top module: `perf_counter_group`

## Requirements
- R1: After reset, the counters, the count and interrupt enables, the overflow flags, the control register (0xE04) and the interrupt control register (0xE50) all read zero. The interrupt output is low. The configuration word at 0xE00 holds counters-minus-one in bits 5:0, counter-width-minus-one in bits 13:8 and the global-filter option in bit 23, with all other bits zero.
- R2: Writing a 1 to bit n at 0xC00 (bits 31:0) or 0xC04 (bits 63:32) enables counter n, and writing a 1 at 0xC20/0xC24 disables it. Zero bits leave the other counters unchanged. Both addresses read back the current enables.
- R3: An enabled counter adds one on each clock edge where bit 0 of 0xE04 is set, the input pulse selected by its event code is high, and the StreamID passes its filter. Otherwise the counter holds its value.
- R4: A counter that increments from all ones becomes zero and sets its overflow flag.
- R5: The overflow flags read at both 0xCC0 and 0xC80. Writing ones at 0xC80 clears those flags, and writing ones at 0xCC0 sets them. A flag raised by a wrap in the same cycle as a clear stays set.
- R6: The interrupt output is high exactly while bit 0 of 0xE50 is set and some overflow flag has its interrupt enable set (set at 0xC40, clear at 0xC60).
- R7: The event-type register of counter n is at 0x400+4n, with the event code in bits 15:0 and the span bit in bit 29. Codes at or above the number of event inputs never count. With span 0, an event counts only when its StreamID equals the match register at 0xA00+4n.
- R8: With span 1, the match register's trailing ones and the zero just above them mark the low bits to ignore, and the remaining upper bits must equal the StreamID. A match register of all ones matches every StreamID.
- R9: With the global-filter option, every counter uses counter 0's span bit and match register, and its own filter settings are ignored. Each counter still uses its own event code.
- R10: Counter, event-type and match slots at or above the counter count read zero and ignore writes. Enable and overflow bits at or above the counter count read zero.
- R11: Counters up to 32 bits wide are at offset 4n. Wider counters are at offset 8n, with bits 31:0 at +0 and the upper bits at +4, zero-extended, and each half is writable on its own.
- R12: The 128-bit supported-event map is readable as four words at 0xE20, 0xE24, 0xE28 and 0xE2C, least significant word first.
- R13: After reset, each event-type register reads with span 1 and code 0, and each match register reads all ones, so an unconfigured filter passes every StreamID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_pulse | input | NUM_EVT | One pulse line per event code |
| evt_sid | input | SID_W | StreamID of the current cycle's events |
| irq | output | 1 | Level interrupt |

## Verification
Most internal faults show up as a wrong count. A wrong filter mask, a lost enable bit or a bad wrap shows in the counter value one edge after the offending pulse. The bench reads that value back through the register port before the next pulse is driven. A wrap that fails to raise its flag, or a clear that also removes a flag it should have kept, shows at the interrupt output and at the overflow views on the next edge. A decode fault shows as an echo at an unimplemented slot or a missing word in the enable views. The global-filter build separates counters that share an event code but have conflicting filters, so a counter that follows the wrong filter gives the wrong count at once.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam logic [11:0] A_EVT_BASE  = 12'h400;
  localparam logic [11:0] A_SID_BASE  = 12'hA00;
  localparam logic [11:0] A_CNTEN_SET = 12'hC00;
  localparam logic [11:0] A_CNTEN_CLR = 12'hC20;
  localparam logic [11:0] A_INTEN_SET = 12'hC40;
  localparam logic [11:0] A_INTEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR   = 12'hC80;
  localparam logic [11:0] A_OVF_SET   = 12'hCC0;
  localparam logic [11:0] A_CONFIG    = 12'hE00;
  localparam logic [11:0] A_CONTROL   = 12'hE04;
  localparam logic [11:0] A_SUPPORT   = 12'hE20;
  localparam logic [11:0] A_IRQCTL    = 12'hE50;

  localparam int SPAN_BIT = 29;

  // Filter decision: exact compare, or pattern compare where the trailing
  // ones of the pattern plus the zero above them mark ignored bits.
  function automatic logic sid_hit(input logic [31:0] pat, input logic [31:0] sid,
                                   input logic span, input logic [31:0] wmask);
    logic [31:0] ign;
    ign = span ? ((pat ^ (pat + 32'd1)) & wmask) : 32'd0;
    return (((pat ^ sid) & wmask & ~ign) == 32'd0);
  endfunction

  function automatic logic [31:0] cfg_word(input int n, input int w, input logic g);
    logic [31:0] c;
    c = 32'd0;
    c[5:0]  = 6'(n - 1);
    c[13:8] = 6'(w - 1);
    c[23]   = g;
    return c;
  endfunction

  function automatic logic [31:0] evt_word(input logic [15:0] code, input logic span);
    logic [31:0] r;
    r = {16'd0, code};
    r[SPAN_BIT] = span;
    return r;
  endfunction

endpackage

// File: rtl/pcg_bitmask.sv
module pcg_bitmask #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] q
);

  logic [N-1:0] sw_set;
  logic [N-1:0] sw_clr;

  assign sw_set = set_we ? wbits : '0;
  assign sw_clr = clr_we ? wbits : '0;

  // Hardware set wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~sw_clr) | sw_set | hw_set;
  end

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wbits)) == $past(wbits)));

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wbits) & ~$past(hw_set)) == '0));

  p_hw_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/pcg_ctr.sv
module pcg_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [31:0]  wdata,
  output logic [W-1:0] value,
  output logic         wrap
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic wr_any;
  assign wr_any = wr_lo | wr_hi;
  assign wrap   = inc && !wr_any && (value == ALL_ONES);

  generate
    if (W > 32) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (wr_lo) value[31:0] <= wdata;
        else if (wr_hi) value[W-1:32] <= wdata[W-33:0];
        else if (inc)   value <= value + 1'b1;
      end
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (wr_any) value <= wdata[W-1:0];
        else if (inc)    value <= value + 1'b1;
      end
    end
  endgenerate

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_any) |=> $stable(value));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_any) |=> (value == $past(value) + 1'b1));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));

endmodule

// File: rtl/perf_counter_group.sv
module perf_counter_group
  import pcg_pkg::*;
#(
  parameter int           NUM_CTR       = 4,
  parameter int           CTR_W         = 32,
  parameter int           SID_W         = 16,
  parameter int           NUM_EVT       = 8,
  parameter bit           GLOBAL_FILTER = 1'b0,
  parameter logic [127:0] EVT_SUPPORT   = 128'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [SID_W-1:0]   evt_sid,
  output logic               irq
);

  localparam int          CSH      = (CTR_W > 32) ? 3 : 2;
  localparam int          CIW      = 10 - CSH;
  localparam int          EVT_IW   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [31:0] SID_MASK = (SID_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << SID_W) - 32'd1);
  localparam logic [31:0] CFG      = cfg_word(NUM_CTR, CTR_W, GLOBAL_FILTER);

  // ---------------- address decode ----------------
  logic           word_ok, in_ctr, in_evt, in_sid, hi_sel;
  logic [CIW-1:0] ctr_idx;
  logic [5:0]     tbl_idx;
  logic           wr_ok;

  assign word_ok = (reg_addr[1:0] == 2'b00);
  assign wr_ok   = reg_wr && word_ok;
  assign in_ctr  = (reg_addr[11:10] == 2'b00);
  assign in_evt  = (reg_addr[11:8] == A_EVT_BASE[11:8]);
  assign in_sid  = (reg_addr[11:8] == A_SID_BASE[11:8]);
  assign ctr_idx = reg_addr[9:CSH];
  assign tbl_idx = reg_addr[7:2];
  assign hi_sel  = (CTR_W > 32) ? reg_addr[2] : 1'b0;

  function automatic logic at_pair(input logic [11:0] a, input logic [11:0] base);
    return (a[11:3] == base[11:3]);
  endfunction

  function automatic logic [NUM_CTR-1:0] lane_bits(input logic [31:0] d, input logic hi);
    logic [NUM_CTR-1:0] r;
    for (int i = 0; i < NUM_CTR; i++)
      r[i] = (i < 32) ? (!hi && d[i % 32]) : (hi && d[i % 32]);
    return r;
  endfunction

  function automatic logic [31:0] mask_word(input logic [NUM_CTR-1:0] q, input logic hi);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      int k;
      k = hi ? i + 32 : i;
      r[i] = (k < NUM_CTR) ? q[k % NUM_CTR] : 1'b0;
    end
    return r;
  endfunction

  // ---------------- global control ----------------
  logic ctl_en, irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == A_CONTROL) ctl_en <= reg_wdata[0];
      if (wr_ok && reg_addr == A_IRQCTL)  irq_en <= reg_wdata[0];
    end
  end

  // ---------------- set/clear registers ----------------
  logic [NUM_CTR-1:0] wbits;
  logic [NUM_CTR-1:0] cnten_q, inten_q, ovf_q;
  logic [NUM_CTR-1:0] wrap_vec;
  logic [NUM_CTR-1:0] inc_vec;

  assign wbits = lane_bits(reg_wdata, reg_addr[2]);

  pcg_bitmask #(.N(NUM_CTR)) u_cnten (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_ok && at_pair(reg_addr, A_CNTEN_SET)),
    .clr_we(wr_ok && at_pair(reg_addr, A_CNTEN_CLR)),
    .wbits(wbits), .hw_set('0), .q(cnten_q));

  pcg_bitmask #(.N(NUM_CTR)) u_inten (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_ok && at_pair(reg_addr, A_INTEN_SET)),
    .clr_we(wr_ok && at_pair(reg_addr, A_INTEN_CLR)),
    .wbits(wbits), .hw_set('0), .q(inten_q));

  pcg_bitmask #(.N(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_ok && at_pair(reg_addr, A_OVF_SET)),
    .clr_we(wr_ok && at_pair(reg_addr, A_OVF_CLR)),
    .wbits(wbits), .hw_set(wrap_vec), .q(ovf_q));

  // ---------------- per-counter slices ----------------
  logic [15:0]      evt_code [NUM_CTR];
  logic             evt_span [NUM_CTR];
  logic [SID_W-1:0] sid_pat  [NUM_CTR];
  logic [CTR_W-1:0] ctr_val  [NUM_CTR];

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic ev_we, sid_we, wr_lo, wr_hi;
      logic use_span;
      logic [SID_W-1:0] use_pat;
      logic sel_pulse, pass;

      assign ev_we  = wr_ok && in_evt && (tbl_idx == 6'(i));
      assign sid_we = wr_ok && in_sid && (tbl_idx == 6'(i));
      assign wr_lo  = wr_ok && in_ctr && (ctr_idx == CIW'(i)) && !hi_sel;
      assign wr_hi  = wr_ok && in_ctr && (ctr_idx == CIW'(i)) && hi_sel;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          evt_code[i] <= 16'd0;
          evt_span[i] <= 1'b1;
          sid_pat[i]  <= '1;
        end else begin
          if (ev_we) begin
            evt_code[i] <= reg_wdata[15:0];
            evt_span[i] <= reg_wdata[SPAN_BIT];
          end
          if (sid_we) sid_pat[i] <= reg_wdata[SID_W-1:0];
        end
      end

      if (GLOBAL_FILTER) begin : g_shared
        assign use_span = evt_span[0];
        assign use_pat  = sid_pat[0];
      end else begin : g_own
        assign use_span = evt_span[i];
        assign use_pat  = sid_pat[i];
      end

      assign sel_pulse = (evt_code[i] < 16'(NUM_EVT)) && evt_pulse[evt_code[i][EVT_IW-1:0]];
      assign pass      = sid_hit(32'(use_pat), 32'(evt_sid), use_span, SID_MASK);
      assign inc_vec[i] = ctl_en && cnten_q[i] && sel_pulse && pass;

      pcg_ctr #(.W(CTR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
        .value(ctr_val[i]), .wrap(wrap_vec[i]));
    end
  endgenerate

  // ---------------- read mux ----------------
  always_comb begin
    logic [63:0] wide;
    wide      = 64'd0;
    reg_rdata = 32'd0;
    if (word_ok) begin
      if (in_ctr) begin
        for (int i = 0; i < NUM_CTR; i++)
          if (ctr_idx == CIW'(i)) wide = 64'(ctr_val[i]);
        reg_rdata = hi_sel ? wide[63:32] : wide[31:0];
      end else if (in_evt) begin
        for (int i = 0; i < NUM_CTR; i++)
          if (tbl_idx == 6'(i)) reg_rdata = evt_word(evt_code[i], evt_span[i]);
      end else if (in_sid) begin
        for (int i = 0; i < NUM_CTR; i++)
          if (tbl_idx == 6'(i)) reg_rdata = 32'(sid_pat[i]);
      end else if (at_pair(reg_addr, A_CNTEN_SET) || at_pair(reg_addr, A_CNTEN_CLR)) begin
        reg_rdata = mask_word(cnten_q, reg_addr[2]);
      end else if (at_pair(reg_addr, A_INTEN_SET) || at_pair(reg_addr, A_INTEN_CLR)) begin
        reg_rdata = mask_word(inten_q, reg_addr[2]);
      end else if (at_pair(reg_addr, A_OVF_SET) || at_pair(reg_addr, A_OVF_CLR)) begin
        reg_rdata = mask_word(ovf_q, reg_addr[2]);
      end else if (reg_addr[11:4] == A_SUPPORT[11:4]) begin
        reg_rdata = EVT_SUPPORT[{reg_addr[3:2], 5'b00000} +: 32];
      end else if (reg_addr == A_CONFIG) begin
        reg_rdata = CFG;
      end else if (reg_addr == A_CONTROL) begin
        reg_rdata = {31'd0, ctl_en};
      end else if (reg_addr == A_IRQCTL) begin
        reg_rdata = {31'd0, irq_en};
      end
    end
  end

  assign irq = irq_en && ((ovf_q & inten_q) != '0);

  // ---------------- assertions ----------------
  p_wrap_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0));

  p_irq_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && reg_addr == A_IRQCTL && !reg_wdata[0]) |=> !irq);

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && reg_addr == A_CONTROL && !reg_wdata[0]) |=> (inc_vec == '0));

endmodule

// File: tb/sim_perf_counter_group.sv
module sim_perf_counter_group;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [11:0] addr = 12'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata0, rdata1;
  logic [7:0]  pulse = 8'd0;
  logic [15:0] sid = 16'd0;
  logic        irq0, irq1;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [127:0] SUPP = 128'hDEAD0001_00000080_CAFE0000_000000FF;

  always #5 clk = ~clk;

  perf_counter_group #(.NUM_CTR(4), .CTR_W(32), .SID_W(16), .NUM_EVT(8),
                       .GLOBAL_FILTER(1'b0), .EVT_SUPPORT(SUPP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata0), .evt_pulse(pulse), .evt_sid(sid), .irq(irq0));

  perf_counter_group #(.NUM_CTR(3), .CTR_W(48), .SID_W(16), .NUM_EVT(8),
                       .GLOBAL_FILTER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata1), .evt_pulse(pulse), .evt_sid(sid), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (which == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input int which, input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = (which == 0) ? rdata0 : rdata1;
  endtask

  task automatic fire(input logic [7:0] p, input logic [15:0] s, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      pulse = p; sid = s;
    end
    @(negedge clk);
    pulse = 8'd0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 12'hE00, v); chk("R1 config", v, 32'h0000_1F03);
    rd(0, 12'hE04, v); chk("R1 control", v, 0);
    rd(0, 12'hE50, v); chk("R1 irq control", v, 0);
    rd(0, 12'hC00, v); chk("R1 count enables", v, 0);
    rd(0, 12'hC40, v); chk("R1 irq enables", v, 0);
    rd(0, 12'hCC0, v); chk("R1 overflow", v, 0);
    rd(0, 12'h004, v); chk("R1 counter", v, 0);
    chk("R1 irq low", {31'd0, irq0}, 0);
    rd(1, 12'hE00, v); chk("R1 config wide/global", v, 32'h0080_2F02);
    rd(0, 12'h408, v); chk("R13 event type reset", v, 32'h2000_0000);
    rd(0, 12'hA08, v); chk("R13 match reset", v, 32'h0000_FFFF);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    wr(0, 12'hC00, 32'h5);
    rd(0, 12'hC00, v); chk("R2 set view", v, 32'h5);
    rd(0, 12'hC20, v); chk("R2 clear view", v, 32'h5);
    wr(0, 12'hC20, 32'h1);
    rd(0, 12'hC00, v); chk("R2 clear one bit", v, 32'h4);
    wr(0, 12'hC20, 32'h4);
    rd(0, 12'hC00, v); chk("R2 all cleared", v, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(0, 12'hE04, 32'h1);
    wr(0, 12'h404, 32'h2000_0002);
    wr(0, 12'hC00, 32'h2);
    fire(8'h04, 16'h1234, 3);
    fire(8'h04, 16'h0007, 2);
    rd(0, 12'h004, v); chk("R3 R13 counts any sid", v, 5);
    rd(0, 12'h000, v); chk("R3 disabled counter idle", v, 0);
    wr(0, 12'hE04, 32'h0);
    fire(8'h04, 16'h1234, 3);
    rd(0, 12'h004, v); chk("R3 global enable off", v, 5);
    wr(0, 12'hE04, 32'h1);
    fire(8'h02, 16'h1234, 2);
    rd(0, 12'h004, v); chk("R3 other event ignored", v, 5);
    wr(0, 12'hC20, 32'h2);
    fire(8'h04, 16'h1234, 2);
    rd(0, 12'h004, v); chk("R2 R3 counter disabled", v, 5);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(0, 12'h408, 32'h2000_0003);
    wr(0, 12'h008, 32'hFFFF_FFFE);
    wr(0, 12'hC00, 32'h4);
    fire(8'h08, 16'h0001, 1);
    rd(0, 12'h008, v); chk("R4 reach all ones", v, 32'hFFFF_FFFF);
    rd(0, 12'hCC0, v); chk("R4 no flag yet", v, 0);
    fire(8'h08, 16'h0001, 1);
    rd(0, 12'h008, v); chk("R4 wrapped to zero", v, 0);
    rd(0, 12'hCC0, v); chk("R4 R5 flag set view", v, 32'h4);
    rd(0, 12'hC80, v); chk("R5 flag clear view", v, 32'h4);
    chk("R6 no irq without enables", {31'd0, irq0}, 0);
    wr(0, 12'hC40, 32'h4);
    chk("R6 no irq without gate", {31'd0, irq0}, 0);
    wr(0, 12'hE50, 32'h1);
    chk("R6 irq raised", {31'd0, irq0}, 1);
    wr(0, 12'hC60, 32'h4);
    chk("R6 irq per-counter disable", {31'd0, irq0}, 0);
    wr(0, 12'hC40, 32'h4);
    chk("R6 irq back", {31'd0, irq0}, 1);
    wr(0, 12'hC80, 32'h4);
    rd(0, 12'hCC0, v); chk("R5 cleared", v, 0);
    chk("R6 irq after clear", {31'd0, irq0}, 0);
    wr(0, 12'hCC0, 32'h1);
    rd(0, 12'hCC0, v); chk("R5 software set", v, 32'h1);
    chk("R6 flag without its enable", {31'd0, irq0}, 0);
    wr(0, 12'hC80, 32'h1);
    wr(0, 12'hC20, 32'h4);
  endtask

  task automatic t_filters();
    logic [31:0] v;
    wr(0, 12'h40C, 32'h0000_0005);
    wr(0, 12'hA0C, 32'h0000_0042);
    wr(0, 12'hC00, 32'h8);
    fire(8'h20, 16'h0042, 1);
    fire(8'h20, 16'h0043, 1);
    fire(8'h20, 16'h0042, 1);
    fire(8'h20, 16'h0142, 1);
    rd(0, 12'h00C, v); chk("R7 exact match", v, 2);
    rd(0, 12'h40C, v); chk("R7 event type readback", v, 32'h5);
    wr(0, 12'h40C, 32'h0000_0009);
    fire(8'hFF, 16'h0042, 2);
    rd(0, 12'h00C, v); chk("R7 code beyond inputs", v, 2);
    wr(0, 12'h400, 32'h2000_0006);
    wr(0, 12'hA00, 32'h0000_0042);
    wr(0, 12'hC00, 32'h1);
    fire(8'h40, 16'h0042, 1);
    fire(8'h40, 16'h0043, 1);
    fire(8'h40, 16'h0040, 1);
    fire(8'h40, 16'h0044, 1);
    rd(0, 12'h000, v); chk("R8 pattern one bit", v, 2);
    wr(0, 12'h000, 32'h0);
    wr(0, 12'hA00, 32'h0000_0041);
    for (int s = 16'h40; s <= 16'h44; s++) fire(8'h40, 16'(s), 1);
    rd(0, 12'h000, v); chk("R8 pattern two bits", v, 4);
  endtask

  task automatic t_absent();
    logic [31:0] v;
    wr(0, 12'h010, 32'h55);
    rd(0, 12'h010, v); chk("R10 absent counter", v, 0);
    wr(0, 12'h410, 32'h7);
    rd(0, 12'h410, v); chk("R10 absent event type", v, 0);
    wr(0, 12'hC00, 32'hFFFF_FFFF);
    rd(0, 12'hC00, v); chk("R10 enables trimmed", v, 32'hF);
    rd(0, 12'hC04, v); chk("R10 upper enables", v, 0);
    wr(0, 12'hC20, 32'hFFFF_FFFF);
    wr(0, 12'hCC0, 32'hF0);
    rd(0, 12'hCC0, v); chk("R10 overflow trimmed", v, 0);
  endtask

  task automatic t_support();
    logic [31:0] v;
    rd(0, 12'hE20, v); chk("R12 word0", v, 32'h0000_00FF);
    rd(0, 12'hE24, v); chk("R12 word1", v, 32'hCAFE_0000);
    rd(0, 12'hE28, v); chk("R12 word2", v, 32'h0000_0080);
    rd(0, 12'hE2C, v); chk("R12 word3", v, 32'hDEAD_0001);
  endtask

  task automatic t_global_wide();
    logic [31:0] v;
    wr(1, 12'hE04, 32'h1);
    wr(1, 12'h400, 32'h0000_0001);
    wr(1, 12'hA00, 32'h0000_0010);
    wr(1, 12'h404, 32'h2000_0001);
    wr(1, 12'hC00, 32'h3);
    fire(8'h02, 16'h0010, 1);
    fire(8'h02, 16'h0011, 1);
    fire(8'h02, 16'h0010, 1);
    rd(1, 12'h000, v); chk("R9 counter0 filter", v, 2);
    rd(1, 12'h008, v); chk("R9 R11 counter1 follows counter0 filter", v, 2);
    rd(1, 12'h00C, v); chk("R11 upper word", v, 0);
    wr(1, 12'h408, 32'h0000_0001);
    wr(1, 12'h010, 32'hFFFF_FFFF);
    wr(1, 12'h014, 32'h0000_FFFF);
    rd(1, 12'h014, v); chk("R11 upper preload", v, 32'h0000_FFFF);
    rd(1, 12'h010, v); chk("R11 lower preload", v, 32'hFFFF_FFFF);
    wr(1, 12'hC00, 32'h4);
    fire(8'h02, 16'h0010, 1);
    rd(1, 12'h010, v); chk("R11 R4 wide wrap lower", v, 0);
    rd(1, 12'h014, v); chk("R11 R4 wide wrap upper", v, 0);
    rd(1, 12'hCC0, v); chk("R4 wide flag", v, 32'h4);
    rd(1, 12'h000, v); chk("R9 counter0 continues", v, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_count();
    t_wrap();
    t_filters();
    t_absent();
    t_support();
    t_global_wide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule